// File: doc/BRIEF.md
# Oscillator Steering Loop Locked to a One-Pulse-Per-Second Reference

The block steers a voltage-controlled crystal oscillator towards an exact frequency by using a satellite receiver's once-per-second pulse as its reference. It runs on the oscillator's own clock. That clock is divided into a one-microsecond tick, and the block counts ticks between consecutive reference pulses. At each pulse the interval is compared with the nominal count. The control code for the oscillator's DAC then moves one step up when the interval is short and one step down when it is long. Because each correction is a single fixed step, the loop behaves as a bang-bang frequency lock. The DAC code leaves the block as a parallel word. Serialising it towards the converter happens elsewhere.

When the pulses stop for one and a half nominal seconds, the block declares the reference lost and freezes the code. The oscillator then coasts on its last setting. The first pulse after reset, and the first pulse after a loss, only restart the interval count. Steering resumes from the pulse after that.

A separate free-running microsecond counter provides a timestamp that the pulse never restarts. When the sampling system signals that a sample buffer has been filled, the block latches the timestamp as that buffer's tag. Individual samples carry no tag.

Top module: `pps_discipline`

## Requirements
- R1: The microsecond tick fires once every CLK_DIV clock cycles. `us_now` starts at 0 after reset and, after n clock cycles out of reset, equals floor(n / CLK_DIV) modulo 2^TAG_W.
- R2: `pps_in` passes through a two-stage synchronizer and a rising-edge detector. A pulse that stays high for many cycles counts as one event and causes at most one DAC step.
- R3: At a steering event whose interval is less than NOMINAL ticks, `dac_code` increases by STEP.
- R4: At a steering event whose interval is greater than NOMINAL, `dac_code` decreases by STEP. An interval equal to NOMINAL leaves `dac_code` unchanged.
- R5: Every detected pulse restarts the interval count. At each steering event, `interval_us` reports the number of ticks since the previous pulse, which is the pulse spacing in cycles divided by CLK_DIV.
- R6: `dac_code` saturates: it never rises above 2^DAC_W-1 and never falls below 0.
- R7: After reset, `dac_code` equals DAC_INIT and `locked`, `lock_lost` and `tag_valid` are 0. The first pulse after reset leaves `dac_code` unchanged and sets `locked`.
- R8: If LOSS_LIMIT = NOMINAL + NOMINAL/2 ticks pass without a pulse while locked, `lock_lost` goes to 1 and `locked` to 0. `dac_code` holds its value while `lock_lost` is 1. A spacing of LOSS_LIMIT-1 ticks does not count as a loss.
- R9: The first pulse after a loss clears `lock_lost` and sets `locked` without changing `dac_code`. The next pulse steers normally.
- R10: When `buffer_done` is high in a cycle, `tag_out` takes the value `us_now` had in that cycle, and `tag_valid` is 1 for exactly the following cycle.
- R11: `us_now` runs freely and wraps modulo 2^TAG_W. Reference pulses do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous one-pulse-per-second reference |
| buffer_done | input | 1 | One-cycle pulse: a sample buffer has been filled |
| dac_code | output | DAC_W | Oscillator steering word |
| locked | output | 1 | Loop is tracking the reference |
| lock_lost | output | 1 | Reference missing, code frozen |
| interval_us | output | CNT_W | Ticks counted in the last pulse interval |
| us_now | output | TAG_W | Free-running microsecond time |
| tag_out | output | TAG_W | Time tag of the last completed buffer |
| tag_valid | output | 1 | Pulses for one cycle when tag_out updates |

## Verification
The bench drives pulse spacings just below, at and just above nominal. It steps the code into both rails to expose a code that wraps instead of saturating. It tries spacings one tick inside and well beyond the loss limit, which catches a watchdog that is off by one or that lets a pulse steer after a loss, so the first pulse after a gap would wrongly move the code. A pulse held high for many cycles would step the code repeatedly if the edge detector were missing. Tags are compared against an arithmetic model of the microsecond time across a wrap, so a tag captured one cycle late or a time base that the pulse restarts shows up as a mismatch.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    LS_ACQUIRE  = 2'd0,
    LS_TRACK    = 2'd1,
    LS_HOLDOVER = 2'd2
  } lock_state_t;
endpackage

// File: rtl/pps_tick_div.sv
module pps_tick_div #(
  parameter int CLK_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST);

      // R1: ticks are never back to back when dividing
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_in,
  output logic pps_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pps_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pps_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R2: one event per rising edge, never two in a row
  assert_single_edge_R2: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> !pps_rise);
endmodule

// File: rtl/pps_lock_ctrl.sv
module pps_lock_ctrl
  import pps_pkg::*;
#(
  parameter int NOMINAL    = 1000000,
  parameter int LOSS_LIMIT = 1500000,
  parameter int CNT_W      = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pps_rise,
  output logic             adjust,
  output logic             raise,
  output logic             lower,
  output logic [CNT_W-1:0] interval_q,
  output logic             locked,
  output logic             lost
);
  localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOMINAL);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LOSS_LIMIT);

  lock_state_t      state_q;
  logic [CNT_W-1:0] count_q;
  logic             timeout;

  assign timeout = (count_q == LIM_C) && !pps_rise;
  assign adjust  = pps_rise && (state_q == LS_TRACK);
  assign raise   = count_q < NOM_C;
  assign lower   = count_q > NOM_C;
  assign locked  = (state_q == LS_TRACK);
  assign lost    = (state_q == LS_HOLDOVER);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      interval_q <= '0;
    end else if (pps_rise) begin
      interval_q <= count_q;
      count_q    <= tick ? CNT_W'(1) : '0;
    end else if (tick && count_q != LIM_C) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LS_ACQUIRE;
    else begin
      case (state_q)
        LS_ACQUIRE:  if (pps_rise) state_q <= LS_TRACK;
        LS_TRACK:    if (timeout) state_q <= LS_HOLDOVER;
        LS_HOLDOVER: if (pps_rise) state_q <= LS_TRACK;
        default:     state_q <= LS_ACQUIRE;
      endcase
    end
  end

  // R5: the count restarts on every detected pulse
  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> (count_q <= CNT_W'(1)));
  // R8: loss is only entered from tracking
  assert_loss_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> ($past(state_q) == LS_TRACK));
  // R9: a pulse always leaves holdover
  assert_holdover_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (lost && pps_rise) |=> locked);
endmodule

// File: rtl/pps_dac_step.sv
module pps_dac_step #(
  parameter int DAC_W    = 16,
  parameter int DAC_INIT = 32768,
  parameter int STEP     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adjust,
  input  logic             raise,
  input  logic             lower,
  output logic [DAC_W-1:0] code
);
  localparam logic [DAC_W:0] FULL  = {1'b0, {DAC_W{1'b1}}};
  localparam logic [DAC_W:0] STP_W = (DAC_W+1)'(STEP);

  logic [DAC_W:0] up_sum;
  logic [DAC_W-1:0] up_val, dn_val;

  assign up_sum = {1'b0, code} + STP_W;
  assign up_val = (up_sum > FULL) ? FULL[DAC_W-1:0] : up_sum[DAC_W-1:0];
  assign dn_val = ({1'b0, code} < STP_W) ? '0 : code - STP_W[DAC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) code <= DAC_W'(DAC_INIT);
    else if (adjust && raise) code <= up_val;
    else if (adjust && lower) code <= dn_val;
  end

  // R3: a short interval never lowers the code
  assert_raise_dir_R3: assert property (@(posedge clk) disable iff (rst)
    (adjust && raise) |=> (code >= $past(code)));
  // R4: a long interval never raises the code
  assert_lower_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (adjust && lower) |=> (code <= $past(code)));
  // R6: code stays at the top rail when pushed further up
  assert_top_rail_R6: assert property (@(posedge clk) disable iff (rst)
    (adjust && raise && code == FULL[DAC_W-1:0]) |=> (code == FULL[DAC_W-1:0]));
  // R6: code stays at zero when pushed further down
  assert_bottom_rail_R6: assert property (@(posedge clk) disable iff (rst)
    (adjust && lower && code == '0) |=> (code == '0));
endmodule

// File: rtl/pps_time_tag.sv
module pps_time_tag #(
  parameter int TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             buffer_done,
  output logic [TAG_W-1:0] now,
  output logic [TAG_W-1:0] tag,
  output logic             tag_valid
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else if (tick) now <= now + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag       <= '0;
      tag_valid <= 1'b0;
    end else begin
      tag_valid <= buffer_done;
      if (buffer_done) tag <= now;
    end
  end

  // R10: the tag equals the time seen in the request cycle
  assert_tag_capture_R10: assert property (@(posedge clk) disable iff (rst)
    buffer_done |=> (tag_valid && tag == $past(now)));
  // R11: time only moves forward by one tick at a time
  assert_time_step_R11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(now));
endmodule

// File: rtl/pps_discipline.sv
module pps_discipline #(
  parameter int CLK_DIV     = 10,
  parameter int NOMINAL     = 1000000,
  parameter int DAC_W       = 16,
  parameter int DAC_INIT    = 32768,
  parameter int STEP        = 1,
  parameter int TAG_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LOSS_LIMIT = NOMINAL + NOMINAL / 2,
  localparam int CNT_W      = $clog2(LOSS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_in,
  input  logic             buffer_done,
  output logic [DAC_W-1:0] dac_code,
  output logic             locked,
  output logic             lock_lost,
  output logic [CNT_W-1:0] interval_us,
  output logic [TAG_W-1:0] us_now,
  output logic [TAG_W-1:0] tag_out,
  output logic             tag_valid
);
  logic tick, pps_rise, adjust, raise, lower;

  pps_tick_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .tick(tick));

  pps_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pps_in(pps_in), .pps_rise(pps_rise));

  pps_lock_ctrl #(.NOMINAL(NOMINAL), .LOSS_LIMIT(LOSS_LIMIT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .pps_rise(pps_rise),
    .adjust(adjust), .raise(raise), .lower(lower),
    .interval_q(interval_us), .locked(locked), .lost(lock_lost));

  pps_dac_step #(.DAC_W(DAC_W), .DAC_INIT(DAC_INIT), .STEP(STEP)) u_dac (
    .clk(clk), .rst(rst), .adjust(adjust), .raise(raise), .lower(lower),
    .code(dac_code));

  pps_time_tag #(.TAG_W(TAG_W)) u_tag (
    .clk(clk), .rst(rst), .tick(tick), .buffer_done(buffer_done),
    .now(us_now), .tag(tag_out), .tag_valid(tag_valid));

  // R8: the code is frozen while the reference is lost
  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    lock_lost |=> $stable(dac_code));
  // R7: a pulse seen while not tracking never moves the code
  assert_first_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (pps_rise && !locked) |=> $stable(dac_code));
  // R8: lost and locked are never both set
  assert_flags_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({locked, lock_lost}));
endmodule

// File: tb/pps_discipline_tb.sv
module pps_discipline_tb;
  localparam int D     = 2;
  localparam int NOM   = 20;
  localparam int DW    = 4;
  localparam int INIT  = 14;
  localparam int TW    = 8;
  localparam int FULLV = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps_in = 1'b0;
  logic buffer_done = 1'b0;
  logic [DW-1:0] dac_code;
  logic locked, lock_lost, tag_valid;
  logic [4:0] interval_us;
  logic [TW-1:0] us_now, tag_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_dac;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  pps_discipline #(.CLK_DIV(D), .NOMINAL(NOM), .DAC_W(DW), .DAC_INIT(INIT),
                   .STEP(1), .TAG_W(TW)) u_dut (
    .clk(clk), .rst(rst), .pps_in(pps_in), .buffer_done(buffer_done),
    .dac_code(dac_code), .locked(locked), .lock_lost(lock_lost),
    .interval_us(interval_us), .us_now(us_now), .tag_out(tag_out),
    .tag_valid(tag_valid));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // rising edge now, high for 4 cycles; returns at a falling clock edge
  task automatic pulse();
    @(negedge clk) pps_in = 1'b1;
    repeat (4) @(negedge clk);
    pps_in = 1'b0;
  endtask

  // completes a spacing of ticks*D cycles between rising edges
  task automatic gap(input int ticks);
    repeat (ticks * D - 5) @(negedge clk);
  endtask

  task automatic chk_time();
    chk("R1 us_now", int'(us_now), (cyc / D) % (1 << TW));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk("R7 reset dac", int'(dac_code), INIT);
    chk("R7 reset locked", int'(locked), 0);
    chk("R7 reset lost", int'(lock_lost), 0);
    chk("R7 reset tag_valid", int'(tag_valid), 0);
    chk("R1 reset time", int'(us_now), 0);

    pulse();
    chk("R7 first pulse no step", int'(dac_code), INIT);
    chk("R7 locked", int'(locked), 1);
    gap(18);
    pulse();
    chk("R3 short raises", int'(dac_code), 15);
    chk("R5 interval 18", int'(interval_us), 18);
    gap(20);
    pulse();
    chk("R4 equal holds", int'(dac_code), 15);
    chk("R5 interval 20", int'(interval_us), 20);
    chk_time();
    gap(18);
    pulse();
    chk("R6 top rail", int'(dac_code), FULLV);
    gap(22);
    pulse();
    chk("R4 long lowers", int'(dac_code), 14);
    chk("R5 interval 22", int'(interval_us), 22);
    gap(29);
    pulse();
    chk("R8 limit-1 no loss", int'(lock_lost), 0);
    chk("R8 limit-1 steers", int'(dac_code), 13);
    chk("R5 interval 29", int'(interval_us), 29);

    repeat (64) @(negedge clk);
    chk("R8 lost flag", int'(lock_lost), 1);
    chk("R8 locked cleared", int'(locked), 0);
    chk("R8 dac frozen", int'(dac_code), 13);
    repeat (40) @(negedge clk);
    chk("R8 dac still frozen", int'(dac_code), 13);
    chk_time();

    pulse();
    chk("R9 first after loss no step", int'(dac_code), 13);
    chk("R9 lost cleared", int'(lock_lost), 0);
    chk("R9 relocked", int'(locked), 1);
    gap(18);
    pulse();
    chk("R9 next pulse steers", int'(dac_code), 14);

    exp_dac = 14;
    for (int i = 0; i < 16; i++) begin
      gap(22);
      pulse();
      exp_dac = (exp_dac > 0) ? exp_dac - 1 : 0;
      chk("R6 bottom rail sweep R4", int'(dac_code), exp_dac);
    end

    // held-high pulse: one event only
    gap(18);
    @(negedge clk) pps_in = 1'b1;
    repeat (30) @(negedge clk);
    chk("R2 held pulse one step", int'(dac_code), 1);
    chk("R5 interval before held", int'(interval_us), 18);
    pps_in = 1'b0;
    chk_time();

    // time tags across wrap
    for (int k = 0; k < 12; k++) begin
      repeat (k * 37 + 3) @(negedge clk);
      buffer_done = 1'b1;
      @(negedge clk) buffer_done = 1'b0;
      chk("R10 tag_valid", int'(tag_valid), 1);
      chk("R10 tag value", int'(tag_out), ((cyc - 1) / D) % (1 << TW));
      chk_time();
      @(negedge clk);
      chk("R10 tag_valid one cycle", int'(tag_valid), 0);
    end
    chk("R11 wrapped run", int'(cyc > (D << TW)), 1);
    chk("R11 us_now free", int'(us_now), (cyc / D) % (1 << TW));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule